// File: doc/BRIEF.md
# Parallel Port Extended Control and Service-Interrupt Unit

This block is the register and interrupt-control part of an enhanced parallel port with an 8-bit data path. A host reaches it through a simple address/read/write bus. It decodes three locations: two identification registers at offsets 0x400 and 0x401, and an extended control register at 0x402. It holds a 16-entry byte FIFO. The FIFO can be exercised directly in a FIFO-test mode. Its fill level drives threshold-based service requests.

The unit raises a single-cycle interrupt pulse in two cases. The first is a falling edge on the active-low fault input. The second is a service event, whose meaning depends on DMA enable and the transfer direction. It also gates a DMA request enable for an external DMA controller. The peripheral handshake engines and the DMA controller are outside this block.

Bus reads are combinational: `rdData` is valid in the same cycle as `rdEn`. A FIFO pop and all register writes take effect at the next clock edge. Interrupt pulses appear one cycle after the clock edge that sampled their cause.

Top module: `ecpPortRegs`

## Requirements
- R1: After reset the control register at 0x402 reads 0x11. Mode is 000, the fault-interrupt disable bit (bit 4) is 1, DMA enable and service bit are 0, and empty (bit 0) is 1. `intrPulse` and `dmaReqEn` are 0.
- R2: In config mode (mode field 111), a read of 0x400 returns 0x10. In any mode other than config or FIFO-test (110), reads of 0x400 and 0x401 return 0x00.
- R3: In config mode, a read of 0x401 returns bit 7 = 0, bit 6 = the live level of `irqLineIn`, and bits 5:0 = 0. Writes to 0x401 change nothing.
- R4: At 0x402, bits 7:5 (mode), 4 (fault-interrupt disable), 3 (DMA enable) and 2 (service) read back what was written. Bit 1 reads 1 exactly when the FIFO holds 16 bytes, and bit 0 reads 1 exactly when it holds none. Writes to bits 1:0 are ignored.
- R5: In FIFO-test mode (110), writes to 0x400 push bytes and reads of 0x400 pop them in write order, whatever `dirIn` is. A write to a full FIFO is dropped. A read of an empty FIFO returns 0x00.
- R6: With bit 4 = 0, a high-to-low transition of `faultN` gives exactly one `intrPulse` in the following cycle. With bit 4 = 1, it gives none.
- R7: A write that changes bit 4 from 1 to 0 while `faultN` is low gives one `intrPulse` in the following cycle.
- R8: `dmaReqEn` is 1 exactly when DMA enable is 1 and the service bit is 0.
- R9: With DMA enable = 1, a rising edge of `termCount` while the service bit is 0 sets the service bit and pulses `intrPulse`.
- R10: With DMA enable = 0 and `dirIn` = 0, the condition "at least 8 free bytes" becoming true while the service bit is 0 sets the service bit and pulses `intrPulse`.
- R11: With DMA enable = 0 and `dirIn` = 1, the condition "at least 8 stored bytes" becoming true while the service bit is 0 sets the service bit and pulses `intrPulse`.
- R12: While the service bit is 1, no service event occurs. A software write of 1 to the service bit never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 11 | Register offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (pops the FIFO in test mode) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdEn is high |
| faultN | input | 1 | Active-low fault from the peripheral |
| termCount | input | 1 | DMA terminal count |
| dirIn | input | 1 | Transfer direction (1 = toward host) |
| irqLineIn | input | 1 | Level of the shared interrupt request line |
| dmaReqEn | output | 1 | DMA request enable |
| intrPulse | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench first applies directed patterns. These include identification reads with the interrupt line at both levels, and the 44h/33h/22h FIFO order test under both directions. Overfill and underflow reads show the dropped-write and empty-read behaviour. Fault edges are applied with the interrupt enabled and disabled, and separately from a re-enable write made while the fault is held low; this separates a true edge trigger from a level trigger.

Terminal-count edges with the service bit clear and then set distinguish the DMA service case from the suppression rule. Filling and draining the FIFO across the level of 8 under each direction shows which threshold the direction selects. A seeded random phase then interleaves register writes, FIFO traffic and input toggles. Its purpose is to expose same-cycle interactions between writes and hardware events.

// File: rtl/ecpRegsPkg.sv
package ecpRegsPkg;
  localparam int BYTE_W = 8;
  localparam logic [2:0] MODE_FIFO_TEST = 3'b110;
  localparam logic [2:0] MODE_CONFIG    = 3'b111;
  localparam logic [7:0] CFGA_VALUE     = 8'h10;

  typedef struct packed {
    logic fifoPush;
    logic fifoPop;
    logic ecrWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/ecpFifo.sv
module ecpFifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == FULL_LVL);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ecpCtrl.sv
module ecpCtrl
  import ecpRegsPkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DEPTH      = 16,
  parameter int WR_THRESH  = 8,
  parameter int RD_THRESH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              faultN,
  input  logic              termCount,
  input  logic              dirIn,
  input  logic              irqLineIn,
  input  logic [BYTE_W-1:0] fifoHead,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output ctrlStrobes_t      strb,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] ecrValue,
  output logic              serviceIntr,
  output logic              dmaReqEn,
  output logic              intrPulse
);
  localparam logic [ADDR_W-1:0] OFS_ID0 = ADDR_W'(11'h400);
  localparam logic [ADDR_W-1:0] OFS_ID1 = ADDR_W'(11'h401);
  localparam logic [ADDR_W-1:0] OFS_ECR = ADDR_W'(11'h402);
  localparam logic [CNT_W-1:0]  FREE_LVL = CNT_W'(DEPTH - WR_THRESH);
  localparam logic [CNT_W-1:0]  FILL_LVL = CNT_W'(RD_THRESH);

  logic [2:0] mode;
  logic faultDis, dmaEn;
  logic condNow, condPrev, faultPrev;
  logic svcEvent, faultEvent;

  // bus decode into strobes for the datapath
  always_comb begin
    strb.fifoPush = wrEn && (addr == OFS_ID0) && (mode == MODE_FIFO_TEST);
    strb.fifoPop  = rdEn && (addr == OFS_ID0) && (mode == MODE_FIFO_TEST);
    strb.ecrWrite = wrEn && (addr == OFS_ECR);
  end

  assign ecrValue = {mode, faultDis, dmaEn, serviceIntr, fifoFull, fifoEmpty};

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == OFS_ECR)
        rdData = ecrValue;
      else if (addr == OFS_ID1 && mode == MODE_CONFIG)
        rdData = {1'b0, irqLineIn, 6'b0};
      else if (addr == OFS_ID0 && mode == MODE_CONFIG)
        rdData = CFGA_VALUE;
      else if (addr == OFS_ID0 && mode == MODE_FIFO_TEST && !fifoEmpty)
        rdData = fifoHead;
    end
  end

  // service condition selected by DMA enable and direction
  always_comb begin
    if (dmaEn)      condNow = termCount;
    else if (dirIn) condNow = (fifoCount >= FILL_LVL);
    else            condNow = (fifoCount <= FREE_LVL);
  end

  assign svcEvent   = condNow && !condPrev && !serviceIntr;
  assign faultEvent = (!faultDis && faultPrev && !faultN) ||
                      (strb.ecrWrite && faultDis && !wrData[4] && !faultN);
  assign dmaReqEn   = dmaEn && !serviceIntr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode        <= 3'b000;
      faultDis    <= 1'b1;
      dmaEn       <= 1'b0;
      serviceIntr <= 1'b0;
      condPrev    <= 1'b1;
      faultPrev   <= 1'b1;
      intrPulse   <= 1'b0;
    end else begin
      condPrev  <= condNow;
      faultPrev <= faultN;
      intrPulse <= svcEvent || faultEvent;
      if (strb.ecrWrite) begin
        mode     <= wrData[7:5];
        faultDis <= wrData[4];
        dmaEn    <= wrData[3];
      end
      if (svcEvent)           serviceIntr <= 1'b1;
      else if (strb.ecrWrite) serviceIntr <= wrData[2];
    end
  end
endmodule

// File: rtl/ecpPortRegs.sv
module ecpPortRegs
  import ecpRegsPkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DEPTH     = 16,
  parameter int WR_THRESH = 8,
  parameter int RD_THRESH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              faultN,
  input  logic              termCount,
  input  logic              dirIn,
  input  logic              irqLineIn,
  output logic              dmaReqEn,
  output logic              intrPulse
);
  ctrlStrobes_t      strb;
  logic [BYTE_W-1:0] fifoHead, ecrValue;
  logic [CNT_W-1:0]  fifoCount;
  logic              fifoFull, fifoEmpty, serviceIntr;

  ecpFifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) fifo_i (
    .clk(clk), .rstN(rstN),
    .push(strb.fifoPush), .pop(strb.fifoPop), .pushData(wrData),
    .headData(fifoHead), .count(fifoCount), .full(fifoFull), .empty(fifoEmpty)
  );

  ecpCtrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WR_THRESH(WR_THRESH),
            .RD_THRESH(RD_THRESH)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .faultN(faultN), .termCount(termCount), .dirIn(dirIn),
    .irqLineIn(irqLineIn), .fifoHead(fifoHead), .fifoCount(fifoCount),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .strb(strb), .rdData(rdData),
    .ecrValue(ecrValue), .serviceIntr(serviceIntr), .dmaReqEn(dmaReqEn),
    .intrPulse(intrPulse)
  );
endmodule

// File: rtl/ecpPortRegsChk.sv
module ecpPortRegsChk
  import ecpRegsPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic [BYTE_W-1:0] rdData,
  input ctrlStrobes_t      strb,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              fifoFull,
  input logic [BYTE_W-1:0] ecrValue,
  input logic              serviceIntr,
  input logic              dmaReqEn,
  input logic              intrPulse
);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && strb.fifoPush && !strb.fifoPop) |=> $stable(fifoCount));

  p_status_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(11'h402)) |-> (rdData[1:0] != 2'b11));

  p_dma_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    serviceIntr |-> !dmaReqEn);

  p_hw_set_pulses_r12: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(serviceIntr) && !$past(strb.ecrWrite)) |-> intrPulse);

  p_ident_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(11'h400) && ecrValue[7:5] == MODE_CONFIG)
      |-> (rdData == CFGA_VALUE));
endmodule

bind ecpPortRegs ecpPortRegsChk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .rdData(rdData),
  .strb(strb), .fifoCount(fifoCount), .fifoFull(fifoFull),
  .ecrValue(ecrValue), .serviceIntr(serviceIntr), .dmaReqEn(dmaReqEn),
  .intrPulse(intrPulse)
);

// File: tb/ecpPortRegs_tb_top.sv
`timescale 1ns/1ps
module ecpPortRegs_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic faultN = 1'b1, termCount = 1'b0, dirIn = 1'b0, irqLineIn = 1'b0;
  logic dmaReqEn, intrPulse;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ecpPortRegs dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .faultN(faultN), .termCount(termCount),
    .dirIn(dirIn), .irqLineIn(irqLineIn), .dmaReqEn(dmaReqEn),
    .intrPulse(intrPulse)
  );

  // reference state, derived from the requirements
  logic [2:0] mMode;
  logic mDis, mDma, mSi, mCondPrev, mFaultPrev, mPulse;
  logic [7:0] mQ[$];
  string mPulseTag;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [10:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == 11'h402)
      v = {mMode, mDis, mDma, mSi, mQ.size() == 16, mQ.size() == 0};
    else if (a == 11'h401 && mMode == 3'b111)
      v = {1'b0, irqLineIn, 6'b0};
    else if (a == 11'h400 && mMode == 3'b111)
      v = 8'h10;
    else if (a == 11'h400 && mMode == 3'b110 && mQ.size() != 0)
      v = mQ[0];
    return v;
  endfunction

  function automatic string readTag(input logic [10:0] a);
    if (a == 11'h402) return "R4";
    if (a == 11'h401) return "R3";
    if (mMode == 3'b110) return "R5";
    return "R2";
  endfunction

  task automatic modelReset();
    mMode = 3'b000; mDis = 1'b1; mDma = 1'b0; mSi = 1'b0;
    mCondPrev = 1'b1; mFaultPrev = 1'b1; mPulse = 1'b0;
    mQ.delete();
    mPulseTag = "R12";
  endtask

  // advance the reference by one clock edge using the pre-edge inputs
  task automatic modelStep();
    int cnt;
    logic cond, ev, fi, ecrW, inTest;
    cnt = mQ.size();
    if (mDma)       cond = termCount;
    else if (dirIn) cond = (cnt >= 8);
    else            cond = ((16 - cnt) >= 8);
    ev   = cond && !mCondPrev && !mSi;
    ecrW = wrEn && addr == 11'h402;
    fi   = (!mDis && mFaultPrev && !faultN) || (ecrW && mDis && !wrData[4] && !faultN);
    mPulse = ev || fi;
    if (fi) mPulseTag = (ecrW && mDis && !wrData[4]) ? "R7" : "R6";
    else if (ev) mPulseTag = mDma ? "R9" : (dirIn ? "R11" : "R10");
    else mPulseTag = "R12";
    inTest = (mMode == 3'b110) && addr == 11'h400;
    if (wrEn && inTest && cnt < 16) mQ.push_back(wrData);
    if (rdEn && inTest && cnt > 0) void'(mQ.pop_front());
    if (ecrW) begin
      mMode = wrData[7:5]; mDis = wrData[4]; mDma = wrData[3];
    end
    if (ev) mSi = 1'b1;
    else if (ecrW) mSi = wrData[2];
    mCondPrev = cond;
    mFaultPrev = faultN;
  endtask

  task automatic cyc(input logic w, input logic r, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    #1;
    if (r) check(readTag(a), rdData, expRead(a));
    @(posedge clk);
    modelStep();
    #1;
    check(mPulseTag, {7'b0, intrPulse}, {7'b0, mPulse});
    check("R8", {7'b0, dmaReqEn}, {7'b0, mDma && !mSi});
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 11'h0, 8'h0);
  endtask

  task automatic wrReg(input logic [10:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b0, a, d);
  endtask

  task automatic rdReg(input logic [10:0] a);
    cyc(1'b0, 1'b1, a, 8'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0cea));
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    #1;
    check("R1", {6'b0, intrPulse, dmaReqEn}, 8'h00);
    rdReg(11'h402);
    @(negedge clk); rdEn = 1'b1; addr = 11'h402; #1;
    check("R1", rdData, 8'h11);
    rdEn = 1'b0;

    // R2: identification reads invisible outside config mode
    rdReg(11'h400); rdReg(11'h401);
    // R2 R3: config mode reads, cfgB tracks irq line, ignores writes
    wrReg(11'h402, 8'hF0);
    rdReg(11'h400);
    irqLineIn = 1'b1; rdReg(11'h401);
    irqLineIn = 1'b0; rdReg(11'h401);
    wrReg(11'h401, 8'hFF); rdReg(11'h401);
    @(negedge clk); rdEn = 1'b1; addr = 11'h401; irqLineIn = 1'b1; #1;
    check("R3", rdData, 8'h40);
    rdEn = 1'b0; irqLineIn = 1'b0;

    // R4: read/write fields, status bits not writable
    wrReg(11'h402, 8'h33); rdReg(11'h402);
    wrReg(11'h402, 8'h13); rdReg(11'h402);

    // R5: FIFO-test order, both directions
    wrReg(11'h402, 8'hD0);
    dirIn = 1'b1;
    wrReg(11'h400, 8'h44); wrReg(11'h400, 8'h33); wrReg(11'h400, 8'h22);
    dirIn = 1'b0;
    rdReg(11'h400); rdReg(11'h400); rdReg(11'h400);
    rdReg(11'h400);  // empty read returns 0
    // R5 R10: overfill, then drain through the free-space threshold
    for (int i = 0; i < 18; i++) wrReg(11'h400, 8'(8'hA0 + i));
    rdReg(11'h402);
    wrReg(11'h402, 8'hD0);  // clear service bit
    for (int i = 0; i < 16; i++) rdReg(11'h400);
    // R11: fill across the stored-byte threshold toward the host
    wrReg(11'h402, 8'hD0);
    dirIn = 1'b1;
    for (int i = 0; i < 10; i++) wrReg(11'h400, 8'(i));
    rdReg(11'h402);

    // R6: fault edge disabled, then enabled
    wrReg(11'h402, 8'hD4);  // set service bit by software: R12, no pulse
    faultN = 1'b0; idle(2); faultN = 1'b1; idle(1);
    wrReg(11'h402, 8'hC4);
    faultN = 1'b0; idle(3);
    // R7: re-enable while fault held low
    wrReg(11'h402, 8'hD4);
    idle(1);
    wrReg(11'h402, 8'hC4);
    idle(1);
    faultN = 1'b1; idle(1);

    // R9 R12: terminal count with service bit set, then clear
    wrReg(11'h402, 8'hDC);
    termCount = 1'b1; idle(2); termCount = 1'b0; idle(1);
    wrReg(11'h402, 8'hD8);
    termCount = 1'b1; idle(2); termCount = 1'b0; idle(1);
    rdReg(11'h402);

    // seeded random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      d = 8'($urandom);
      if ($urandom_range(0, 7) == 0) faultN = ~faultN;
      if ($urandom_range(0, 5) == 0) termCount = ~termCount;
      if ($urandom_range(0, 15) == 0) dirIn = ~dirIn;
      irqLineIn = 1'($urandom);
      case (op)
        0: wrReg(11'h402, {($urandom_range(0, 3) != 0) ? 3'b110 : d[7:5], d[4:0]});
        1, 2, 3: wrReg(11'h400, d);
        4, 5, 6: rdReg(11'h400);
        7: rdReg(11'h402);
        8: rdReg(11'h401);
        default: cyc(1'($urandom), 1'b0, 11'(11'h400 + $urandom_range(0, 3)), d);
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule